// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block decides which of five DMA channels owns the shared bus master. Each channel presents a request line and a 3-bit priority setting. The arbiter returns a one-hot grant and a flag that shows a grant is held. A channel may raise or drop its request in any cycle. Once a grant is held, it is kept until the bus side pulses `xfer_done_i`. That pulse marks the end of the current burst or single transfer. A more urgent request that arrives in the middle of a transfer therefore waits for the next boundary.

The grant is registered. In the cycle where a decision is taken (bus idle, or boundary pulse present), the arbiter picks the requesting channel whose effective priority is largest. The new grant appears after the next rising clock edge. Priority settings above 5 count as 5. When effective priorities are equal, the lower channel index wins.

Top module: `dma_prio_arb`

## Requirements
- R1: During and directly after reset, `gnt_o` is all zeros and `gnt_valid_o` is low.
- R2: When no grant is held and at least one request is high, the winning channel is granted after the next rising edge.
- R3: Among the channels that are requesting, the one with the largest effective priority is granted. The priority of channel k is `prio_i[3k+2:3k]`, and 0 is the lowest value.
- R4: When requesting channels share the largest effective priority, the lowest channel index is granted.
- R5: Priority values 6 and 7 behave exactly like 5.
- R6: While a grant is held and `xfer_done_i` is low, `gnt_o` does not change on the next edge. This holds even if a higher-priority channel requests, or if the holder drops its request.
- R7: When `xfer_done_i` is high while a grant is held, arbitration is redone over the requests in that same cycle. The result is registered on that edge, and the current holder may win again.
- R8: If there is no request in a cycle where a decision is taken (idle or `xfer_done_i` high), `gnt_o` becomes all zeros and `gnt_valid_o` goes low after the edge.
- R9: `gnt_o` has at most one bit set, and `gnt_valid_o` is high exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Per-channel request for the bus master |
| prio_i | input | 15 | Per-channel priority, 3 bits each, channel 0 in the low bits |
| xfer_done_i | input | 1 | Single-cycle pulse at the end of the current burst or single transfer |
| gnt_o | output | 5 | One-hot grant |
| gnt_valid_o | output | 1 | High while a grant is held |

## Verification
Two events can land in the same cycle: the transfer boundary pulse, and the arrival of a new, more urgent request. In that case the new request must take part in the re-arbitration at once. A higher-priority request raised one cycle earlier must not have broken in.

The bench provokes this collision in two ways:
- Directed steps that raise a priority-5 request first without the boundary pulse, then together with it.
- Random cycles in which the request vector, the priorities and the boundary pulse all change freely.

Every cycle is judged against a bench model of the hold/re-arbitrate rule. The expected owner is compared at the negative edge after each decision edge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_CH   = 5;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned PRIO_TOP = 5;
endpackage

// File: rtl/dma_arb_prio_clamp.sv
module dma_arb_prio_clamp #(
  parameter int unsigned PRIO_W   = dma_arb_pkg::PRIO_W,
  parameter int unsigned PRIO_TOP = dma_arb_pkg::PRIO_TOP
) (
  input  logic [PRIO_W-1:0] raw_i,
  output logic [PRIO_W-1:0] eff_o
);
  localparam logic [PRIO_W-1:0] TOP = PRIO_W'(PRIO_TOP);

  assign eff_o = (raw_i > TOP) ? TOP : raw_i;

  always_comb begin
    a_clamp_range_r5: assert (eff_o <= TOP);
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned NUM_CH = dma_arb_pkg::NUM_CH,
  parameter int unsigned PRIO_W = dma_arb_pkg::PRIO_W
) (
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] eff_prio_i,
  output logic [NUM_CH-1:0]        win_o
);
  logic [PRIO_W-1:0] best;
  logic              found;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    win_o = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[i] && (!found || eff_prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        best  = eff_prio_i[i*PRIO_W +: PRIO_W];
        found = 1'b1;
        win_o = '0;
        win_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_gnt_reg.sv
module dma_arb_gnt_reg #(
  parameter int unsigned NUM_CH = dma_arb_pkg::NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] win_i,
  input  logic              xfer_done_i,
  output logic [NUM_CH-1:0] gnt_q_o
);
  logic decide;

  assign decide = (gnt_q_o == '0) || xfer_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gnt_q_o <= '0;
    else if (decide) gnt_q_o <= win_i;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q_o != '0 && !xfer_done_i) |=> $stable(gnt_q_o));

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q_o));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned NUM_CH   = dma_arb_pkg::NUM_CH,
  parameter int unsigned PRIO_W   = dma_arb_pkg::PRIO_W,
  parameter int unsigned PRIO_TOP = dma_arb_pkg::PRIO_TOP
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     xfer_done_i,
  output logic [NUM_CH-1:0]        gnt_o,
  output logic                     gnt_valid_o
);
  logic [NUM_CH*PRIO_W-1:0] eff_prio;
  logic [NUM_CH-1:0]        win;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_clamp
    dma_arb_prio_clamp #(.PRIO_W(PRIO_W), .PRIO_TOP(PRIO_TOP)) u_clamp (
      .raw_i (prio_i[c*PRIO_W +: PRIO_W]),
      .eff_o (eff_prio[c*PRIO_W +: PRIO_W])
    );
  end

  dma_arb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick (
    .req_i      (req_i),
    .eff_prio_i (eff_prio),
    .win_o      (win)
  );

  dma_arb_gnt_reg #(.NUM_CH(NUM_CH)) u_gnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win),
    .xfer_done_i (xfer_done_i),
    .gnt_q_o     (gnt_o)
  );

  assign gnt_valid_o = |gnt_o;

  p_idle_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && req_i != '0) |=> gnt_valid_o);

  p_new_owner_requested_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !$stable(gnt_o)) |-> ((gnt_o & $past(req_i)) != '0));

  p_empty_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!gnt_valid_o || xfer_done_i) && req_i == '0) |=> !gnt_valid_o);

  p_winner_is_requester_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win & ~req_i) == '0);
endmodule

// File: tb/dma_prio_arb_test.sv
module dma_prio_arb_test;
  localparam int N  = 5;
  localparam int PW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*PW-1:0] prio = '0;
  logic            done = 1'b0;
  logic [N-1:0]    gnt;
  logic            gnt_valid;

  int vectors = 0;
  int miscompares = 0;
  logic [N-1:0] exp_gnt = '0;

  always #5 clk = ~clk;

  dma_prio_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio),
    .xfer_done_i(done), .gnt_o(gnt), .gnt_valid_o(gnt_valid)
  );

  function automatic logic [N-1:0] pick(logic [N-1:0] r, logic [N*PW-1:0] p);
    logic [N-1:0] w = '0;
    int best = -1;
    for (int i = 0; i < N; i++) begin
      int v = int'(p[i*PW +: PW]);
      if (v > 5) v = 5;
      if (r[i] && v > best) begin
        best = v;
        w = '0;
        w[i] = 1'b1;
      end
    end
    return w;
  endfunction

  task automatic check(string tag);
    vectors++;
    if (gnt !== exp_gnt || gnt_valid !== (exp_gnt != '0)) begin
      miscompares++;
      $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b",
               tag, gnt, gnt_valid, exp_gnt, exp_gnt != '0);
    end
  endtask

  // drive at negedge, update model, check at next negedge
  task automatic step(logic [N-1:0] r, logic [N*PW-1:0] p, logic d, string tag);
    req = r; prio = p; done = d;
    if (exp_gnt == '0 || d) exp_gnt = pick(r, p);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    string tag;
    void'($urandom(32'h5eed_0a1b));
    @(negedge clk);
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    check("R1");

    // idle grant
    step(5'b00100, {3'd1,3'd1,3'd1,3'd1,3'd1}, 1'b0, "R2");
    // urgent request mid-transfer must wait
    step(5'b10100, {3'd5,3'd1,3'd1,3'd1,3'd1}, 1'b0, "R6");
    step(5'b10000, {3'd5,3'd1,3'd1,3'd1,3'd1}, 1'b0, "R6 holder dropped");
    // boundary together with urgent request
    step(5'b10100, {3'd5,3'd1,3'd1,3'd1,3'd1}, 1'b1, "R7 R3");
    // holder wins again
    step(5'b10000, {3'd5,3'd1,3'd1,3'd1,3'd1}, 1'b1, "R7 regrant");
    // boundary with no request
    step(5'b00000, {3'd5,3'd1,3'd1,3'd1,3'd1}, 1'b1, "R8");
    step(5'b00000, {3'd5,3'd1,3'd1,3'd1,3'd1}, 1'b0, "R8 idle");
    // tie
    step(5'b01010, {3'd0,3'd3,3'd0,3'd3,3'd0}, 1'b0, "R4");
    // 7 equals 5: lower index wins
    step(5'b01001, {3'd0,3'd7,3'd0,3'd0,3'd5}, 1'b1, "R5 seven");
    step(5'b00011, {3'd0,3'd0,3'd0,3'd6,3'd5}, 1'b1, "R5 six");
    // strict ordering
    step(5'b00110, {3'd0,3'd0,3'd4,3'd6,3'd0}, 1'b1, "R3");
    step(5'b11111, {3'd0,3'd1,3'd2,3'd3,3'd4}, 1'b1, "R3 low wins");
    step(5'b00000, '0, 1'b1, "R8");

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r = N'($urandom);
      logic [N*PW-1:0] p = (N*PW)'($urandom);
      logic d = ($urandom % 4) == 0;
      if (exp_gnt == '0)      tag = (r != '0) ? "R2 rand" : "R8 rand";
      else if (!d)            tag = "R6 rand";
      else if (r == '0)       tag = "R8 rand";
      else                    tag = "R7 rand";
      step(r, p, d, tag);
      if (k % 500 == 0) begin
        rst_n = 1'b0;
        exp_gnt = '0;
        @(negedge clk);
        check("R1 rand");
        rst_n = 1'b1;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule